// File: doc/BRIEF.md
# Software Write-Protection Sequence Detector

This block sits in front of the page-write controller of a byte-wide non-volatile memory. It looks at every byte write strobe (13-bit address, 8-bit data) and decides whether that byte may enter the page buffer. It also tracks whether the memory is in software-protected mode. That mode is entered, or left, only through short command sequences, written as ordinary writes to two fixed addresses.

A three-write unlock prefix (AA at 1555h, 55 at 0AAAh, A0 at 1555h) puts the memory into protected mode and authorises the load sequence that follows it. A six-write release sequence (AA at 1555h, 55 at 0AAAh, 80 at 1555h, AA at 1555h, 55 at 0AAAh, 20 at 1555h) returns the memory to unprotected mode. The bytes of any recognised command step are consumed and never permitted. When the page-write controller starts a programming cycle, it pulses `prog_start`, and this ends the authorisation.

Each write gets a registered verdict one clock later. The protection flag is a register that starts out unprotected.

Top module: `spd_guard`

## Requirements
- R1: While `rst_n` is low and after its release, `protect_on` is 0 and `res_valid` is 0.
- R2: Every write strobe produces exactly one `res_valid` pulse in the following cycle, with its verdict on `res_permit`. Without a strobe, `res_valid` stays 0.
- R3: While unprotected, a write that is not a recognised command step is permitted. This includes a write to 1555h with data other than AA.
- R4: The writes AA@1555h, 55@0AAAh, A0@1555h in consecutive write order set `protect_on` to 1 on the third write. None of the three is permitted.
- R5: After a completed unlock prefix, ordinary writes are permitted until `prog_start` is pulsed. A prefix issued while already protected authorises again.
- R6: While protected and not authorised, ordinary writes are refused.
- R7: The six writes AA@1555h, 55@0AAAh, 80@1555h, AA@1555h, 55@0AAAh, 20@1555h clear `protect_on` on the sixth write. None of the six is permitted, and later ordinary writes are permitted.
- R8: A write that does not match the next expected step abandons the partial sequence and is judged as an ordinary write. It is permitted if the block is unprotected or authorised, and refused otherwise. If that write is itself AA@1555h, it is consumed as the first step of a new sequence.
- R9: A `prog_start` pulse revokes the authorisation and leaves `protect_on` unchanged.
- R10: An interrupted sequence never changes `protect_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-cycle byte write strobe |
| wr_addr | input | 13 | Byte address of the write |
| wr_data | input | 8 | Byte data of the write |
| prog_start | input | 1 | Pulse: programming cycle begins, ends authorisation |
| res_valid | output | 1 | Verdict for the write of the previous cycle is present |
| res_permit | output | 1 | 1: that write may enter the page buffer |
| protect_on | output | 1 | Software protection is active |

## Verification
The verdict of a write and any change of `protect_on` caused by that write are both due one cycle after the strobe. They are registered at the same edge that captures the write. The bench drives its inputs on falling edges, so each strobe is captured on the next rising edge. At that moment the bench queues the expected permit and protection values. The monitor compares them at the falling edge that follows, where the result has settled. A `res_valid` with an empty queue, or a queue left over at the end, exposes a missing or extra verdict.

// File: rtl/spd_pkg.sv
// Shared types for the software write-protection detector.
// Assumes a single write stream; indices name the five command patterns.
package spd_pkg;

    localparam int N_PAT    = 5;
    localparam int PAT_K1   = 0;   // first key byte at the primary address
    localparam int PAT_K2   = 1;   // second key byte at the secondary address
    localparam int PAT_LOCK = 2;   // lock command at the primary address
    localparam int PAT_ESC  = 3;   // escape toward the release sequence
    localparam int PAT_OFF  = 4;   // final release command

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_K1   = 3'd1,
        SQ_K2   = 3'd2,
        SQ_ESC  = 3'd3,
        SQ_K4   = 3'd4,
        SQ_K5   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic hit;    // the write was consumed as a command step
        logic lock;   // unlock prefix completed on this write
        logic clear;  // release sequence completed on this write
    } seq_evt_t;

endpackage

// File: rtl/spd_pattern_match.sv
// Compares one write against the five command patterns.
// Purely combinational; one comparator per pattern, built by generate.
module spd_pattern_match #(
    parameter int                    ADDR_W   = 13,
    parameter int                    DATA_W   = 8,
    parameter logic [ADDR_W-1:0]     ADDR_PRI = 13'h1555,
    parameter logic [ADDR_W-1:0]     ADDR_SEC = 13'h0AAA,
    parameter logic [DATA_W-1:0]     D_KEY1   = 8'hAA,
    parameter logic [DATA_W-1:0]     D_KEY2   = 8'h55,
    parameter logic [DATA_W-1:0]     D_LOCK   = 8'hA0,
    parameter logic [DATA_W-1:0]     D_ESC    = 8'h80,
    parameter logic [DATA_W-1:0]     D_OFF    = 8'h20
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        data,
    output logic [spd_pkg::N_PAT-1:0] pat_hit
);
    import spd_pkg::*;

    localparam logic [ADDR_W-1:0] PAT_ADDR [N_PAT] =
        '{ADDR_PRI, ADDR_SEC, ADDR_PRI, ADDR_PRI, ADDR_PRI};
    localparam logic [DATA_W-1:0] PAT_DATA [N_PAT] =
        '{D_KEY1, D_KEY2, D_LOCK, D_ESC, D_OFF};

    for (genvar gi = 0; gi < N_PAT; gi++) begin : g_cmp
        // One address-and-data comparator per command pattern.
        assign pat_hit[gi] = (addr == PAT_ADDR[gi]) && (data == PAT_DATA[gi]);
    end

endmodule

// File: rtl/spd_seq_fsm.sv
// Step tracker for the unlock prefix and the release sequence.
// Assumes pat_hit is valid whenever wr_valid is high. A write that breaks
// the expected order restarts the tracker, and is itself taken as a
// first step when it is the first key byte.
module spd_seq_fsm (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [spd_pkg::N_PAT-1:0] pat_hit,
    output spd_pkg::seq_evt_t         evt
);
    import spd_pkg::*;

    seq_state_e state_q, state_d;

    // Next step and event flags for the current write.
    always_comb begin
        state_d   = state_q;
        evt       = '0;
        if (wr_valid) begin
            unique case (state_q)
                SQ_K1: begin
                    if (pat_hit[PAT_K2]) begin
                        state_d = SQ_K2;
                        evt.hit = 1'b1;
                    end
                end
                SQ_K2: begin
                    if (pat_hit[PAT_LOCK]) begin
                        state_d  = SQ_IDLE;
                        evt.hit  = 1'b1;
                        evt.lock = 1'b1;
                    end else if (pat_hit[PAT_ESC]) begin
                        state_d = SQ_ESC;
                        evt.hit = 1'b1;
                    end
                end
                SQ_ESC: begin
                    if (pat_hit[PAT_K1]) begin
                        state_d = SQ_K4;
                        evt.hit = 1'b1;
                    end
                end
                SQ_K4: begin
                    if (pat_hit[PAT_K2]) begin
                        state_d = SQ_K5;
                        evt.hit = 1'b1;
                    end
                end
                SQ_K5: begin
                    if (pat_hit[PAT_OFF]) begin
                        state_d   = SQ_IDLE;
                        evt.hit   = 1'b1;
                        evt.clear = 1'b1;
                    end
                end
                default: ;
            endcase
            if (!evt.hit) begin
                // Out-of-order write: restart, possibly as a new first step.
                if (pat_hit[PAT_K1]) begin
                    state_d = SQ_K1;
                    evt.hit = 1'b1;
                end else begin
                    state_d = SQ_IDLE;
                end
            end
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/spd_grant.sv
// Holds the protection flag and the authorisation, and registers the
// per-write verdict. Assumes evt is only set together with wr_valid.
module spd_grant (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  spd_pkg::seq_evt_t evt,
    input  logic              prog_start,
    output logic              protect_on,
    output logic              auth_q,
    output logic              res_valid,
    output logic              res_permit
);
    logic prot_q;
    logic permit_now;

    // Verdict for the write now on the bus.
    always_comb permit_now = !evt.hit && (!prot_q || auth_q);

    // Protection flag and authorisation; command completion wins over prog_start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
            auth_q <= 1'b0;
        end else if (wr_valid && evt.lock) begin
            prot_q <= 1'b1;
            auth_q <= 1'b1;
        end else if (wr_valid && evt.clear) begin
            prot_q <= 1'b0;
            auth_q <= 1'b0;
        end else if (prog_start) begin
            auth_q <= 1'b0;
        end
    end

    // Registered verdict, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_permit <= 1'b0;
        end else begin
            res_valid  <= wr_valid;
            res_permit <= wr_valid && permit_now;
        end
    end

    assign protect_on = prot_q;

endmodule

// File: rtl/spd_guard.sv
// Top of the software write-protection detector. Screens each byte write
// for the page-write controller and tracks the protection mode.
// Assumes one write per strobe cycle and prog_start pulsed by the controller.
module spd_guard #(
    parameter int                ADDR_W   = 13,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_PRI = 13'h1555,
    parameter logic [ADDR_W-1:0] ADDR_SEC = 13'h0AAA,
    parameter logic [DATA_W-1:0] D_KEY1   = 8'hAA,
    parameter logic [DATA_W-1:0] D_KEY2   = 8'h55,
    parameter logic [DATA_W-1:0] D_LOCK   = 8'hA0,
    parameter logic [DATA_W-1:0] D_ESC    = 8'h80,
    parameter logic [DATA_W-1:0] D_OFF    = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_start,
    output logic              res_valid,
    output logic              res_permit,
    output logic              protect_on
);
    import spd_pkg::*;

    logic [N_PAT-1:0] pat_hit;
    seq_evt_t         evt;
    logic             auth_q;

    spd_pattern_match #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ADDR_PRI(ADDR_PRI), .ADDR_SEC(ADDR_SEC),
        .D_KEY1(D_KEY1), .D_KEY2(D_KEY2), .D_LOCK(D_LOCK),
        .D_ESC(D_ESC), .D_OFF(D_OFF)
    ) u_match (
        .addr    (wr_addr),
        .data    (wr_data),
        .pat_hit (pat_hit)
    );

    spd_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .pat_hit  (pat_hit),
        .evt      (evt)
    );

    spd_grant u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .evt        (evt),
        .prog_start (prog_start),
        .protect_on (protect_on),
        .auth_q     (auth_q),
        .res_valid  (res_valid),
        .res_permit (res_permit)
    );

endmodule

// File: rtl/spd_guard_chk.sv
// Property checker for spd_guard, attached by bind below.
module spd_guard_chk (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_valid,
    input logic                      prog_start,
    input logic [spd_pkg::N_PAT-1:0] pat_hit,
    input logic                      auth_q,
    input logic                      res_valid,
    input logic                      res_permit,
    input logic                      protect_on
);
    import spd_pkg::*;

    assert_result_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> res_valid);

    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !res_valid);

    assert_permit_with_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_permit |-> res_valid);

    assert_lock_from_command_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(protect_on) |-> $past(wr_valid && pat_hit[PAT_LOCK]));

    assert_release_from_command_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(protect_on) |-> $past(wr_valid && pat_hit[PAT_OFF]));

    assert_blocked_unless_authorised_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_permit && $past(protect_on)) |-> $past(auth_q));

    assert_prog_start_revokes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start && !wr_valid) |=> (!auth_q && $stable(protect_on)));

endmodule

bind spd_guard spd_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .prog_start (prog_start),
    .pat_hit    (pat_hit),
    .auth_q     (auth_q),
    .res_valid  (res_valid),
    .res_permit (res_permit),
    .protect_on (protect_on)
);

// File: tb/spd_guard_test.sv
// Scoreboard bench: the driver queues expected verdicts, the monitor compares.
module spd_guard_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_start = 1'b0;
    logic        res_valid, res_permit, protect_on;

    int n_cmp = 0;
    int n_bad = 0;
    bit    q_perm [$];
    bit    q_prot [$];
    string q_tag  [$];

    always #2 clk = ~clk;

    spd_guard uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_start(prog_start), .res_valid(res_valid),
        .res_permit(res_permit), .protect_on(protect_on)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One strobe, captured at the next rising edge; verdict queued for the monitor.
    task automatic wr(input logic [12:0] a, input logic [7:0] d,
                      input bit perm, input bit prot, input string tag);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        q_perm.push_back(perm); q_prot.push_back(prot); q_tag.push_back(tag);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_prog;
        prog_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0;
    endtask

    // Monitor: at each falling edge, compare a result against the queue head.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (q_tag.size() == 0) begin
                chk("R2 unexpected result", 1, 0);
            end else begin
                string t;
                bit ep, er;
                t  = q_tag.pop_front();
                ep = q_perm.pop_front();
                er = q_prot.pop_front();
                chk({t, " permit"}, res_permit, ep);
                chk({t, " protect"}, protect_on, er);
            end
        end
    end

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #100000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset protect", protect_on, 0);
        chk("R1 reset valid", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release protect", protect_on, 0);
        chk("R1 after release valid", res_valid, 0);

        // R3: unprotected ordinary writes
        wr(13'h0100, 8'h12, 1, 0, "R3 plain");
        wr(13'h1555, 8'h33, 1, 0, "R3 key addr other data");

        // R4: unlock prefix
        wr(13'h1555, 8'hAA, 0, 0, "R4 step1");
        wr(13'h0AAA, 8'h55, 0, 0, "R4 step2");
        wr(13'h1555, 8'hA0, 0, 1, "R4 step3");

        // R5: authorised load
        wr(13'h0040, 8'h77, 1, 1, "R5 load a");
        wr(13'h0041, 8'h78, 1, 1, "R5 load b");
        @(negedge clk);

        // R9 then R6
        pulse_prog();
        @(negedge clk);
        chk("R9 protect kept", protect_on, 1);
        wr(13'h0042, 8'h79, 0, 1, "R9 revoked");
        wr(13'h1FFF, 8'h01, 0, 1, "R6 blocked");

        // R8 / R10: interrupted sequences while protected
        wr(13'h1555, 8'hAA, 0, 1, "R10 partial step1");
        wr(13'h0123, 8'h11, 0, 1, "R8 mismatch blocked");
        wr(13'h1555, 8'hAA, 0, 1, "R8 step1");
        wr(13'h0AAA, 8'h55, 0, 1, "R8 step2");
        wr(13'h1555, 8'hAA, 0, 1, "R8 restart as step1");
        wr(13'h0AAA, 8'h55, 0, 1, "R8 step2 again");
        wr(13'h1555, 8'hA0, 0, 1, "R5 prefix while protected");
        wr(13'h0200, 8'h5A, 1, 1, "R5 reauthorised");
        wr(13'h1555, 8'hAA, 0, 1, "R8 step1 authorised");
        wr(13'h0300, 8'h99, 1, 1, "R8 mismatch authorised");
        pulse_prog();

        // R7: release sequence
        wr(13'h1555, 8'hAA, 0, 1, "R7 s1");
        wr(13'h0AAA, 8'h55, 0, 1, "R7 s2");
        wr(13'h1555, 8'h80, 0, 1, "R7 s3");
        wr(13'h1555, 8'hAA, 0, 1, "R7 s4");
        wr(13'h0AAA, 8'h55, 0, 1, "R7 s5");
        wr(13'h1555, 8'h20, 0, 0, "R7 s6");
        wr(13'h0500, 8'h44, 1, 0, "R7 after release");

        // R10: interrupted prefix while unprotected
        wr(13'h1555, 8'hAA, 0, 0, "R10 u1");
        wr(13'h0AAA, 8'h55, 0, 0, "R10 u2");
        wr(13'h0001, 8'h44, 1, 0, "R10 break");
        wr(13'h1555, 8'hA0, 1, 0, "R10 lone lock byte");

        repeat (3) @(negedge clk);
        chk("R2 all results seen", q_tag.size(), 0);
        finish_run();
    end

endmodule